// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Bit Read Source

A four-pin general-purpose I/O port that sits on a simple synchronous register bus. Software configures each pin as a driven output, a floating input or an input held high by a pull-up. The block has three registers: an output latch, a direction register and a pull-up enable register. It drives per-pin output-enable, output-value and pull-up-enable lines to a pad model, and it samples the pad levels through a two-flop synchronizer.

A read of the data register is assembled bit by bit. An output bit returns its latch value and an input bit returns the synchronized pin level. The latch accepts writes whatever the direction is, so software can preload an output value before it turns the pin around. The bus uses a one-cycle strobe with a write-enable line. Read data is registered and stays on the bus until the next read.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low at a clock edge, the latch, direction and pull-up registers and the read data all clear to zero, so pad_oe and pad_pu are 0 and every pin is an input.
- R2: pad_oe[i] is 1 exactly when direction bit i is 1, and pad_out carries the latch. The direction register sits at offset 0x04, and a write there changes pad_oe on the following cycle.
- R3: For a bit whose direction is 1, a read of the data register at offset 0x00 returns the latch bit.
- R4: For a bit whose direction is 0, a read of offset 0x00 returns the synchronized pin. A level on pad_in at clock edge k is returned by a read strobed at edge k+2, not by one strobed at edge k+1.
- R5: A write to offset 0x00 always updates the latch, whatever the direction bits. While a bit is an input, that write does not change what a data read returns for the bit. The written value appears once the bit becomes an output.
- R6: pad_pu[i] is 1 only when pull-up bit i is 1 and direction bit i is 0. The pull-up register sits at offset 0x08. An input that has its pull-up on and no external driver reads 1.
- R7: The direction and pull-up registers can be read back. Bus data bits above bit 3 always read as zero.
- R8: Addresses other than 0x00, 0x04 and 0x08 read as zero, and writes to them change no register.
- R9: Read data appears on bus_rdata on the cycle after a read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 4 | Asynchronous pin levels from the pads |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output value |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
Two events can fall in the same cycle: a pin level reaching the synchronizer output, and a data read whose result mixes pin bits with latch bits. The bench changes the external pin drive half a cycle before an edge and then issues back-to-back data reads. The first two reads must still show the old level and the third must show the new one. Latch-driven bits in the same words must stay fixed, and a latch write made while the bit is an input must not leak into any of these reads.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: bus address width, register
// offsets and the decoded register selector.
// Assumes byte offsets compared over the full address width.
package gpio_port_pkg;

    localparam int PORT_AW = 8;

    localparam logic [PORT_AW-1:0] OFS_DATA = 8'h00;
    localparam logic [PORT_AW-1:0] OFS_DIR  = 8'h04;
    localparam logic [PORT_AW-1:0] OFS_PULL = 8'h08;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_DIR  = 2'd2,
        REG_PULL = 2'd3
    } reg_sel_e;

    // Map an offset to the register it names.
    function automatic reg_sel_e decode(input logic [PORT_AW-1:0] addr);
        case (addr)
            OFS_DATA: decode = REG_DATA;
            OFS_DIR:  decode = REG_DIR;
            OFS_PULL: decode = REG_PULL;
            default:  decode = REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
// Two-flop synchronizer, one chain per pad input.
// Assumes pad_in is asynchronous to clk; the output lags the pads by two edges.
module gpio_port_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_s
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Shift each pad level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= pad_in[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign pin_s = stage2;

    // Checking aid: counts edges since reset so the latency check never
    // looks back past the reset.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R4: the synchronized value equals the pad level two edges earlier.
    a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (pin_s == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
// Register file of the GPIO port: output latch, direction and pull-up enable.
// Assumes a one-cycle bus_sel strobe; writes take effect at the strobe edge.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [PORT_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [WIDTH-1:0]   latch_q,
    output logic [WIDTH-1:0]   dir_q,
    output logic [WIDTH-1:0]   pull_q
);

    reg_sel_e         wsel;
    logic             wr;
    logic [WIDTH-1:0] wval;

    // Decode the write target and take the low data bits.
    always_comb begin
        wr   = bus_sel && bus_we;
        wsel = decode(bus_addr);
        wval = bus_wdata[WIDTH-1:0];
    end

    // Update the addressed register; the latch is written whatever the direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
        end else if (wr) begin
            case (wsel)
                REG_DATA: latch_q <= wval;
                REG_DIR:  dir_q   <= wval;
                REG_PULL: pull_q  <= wval;
                default:  ;
            endcase
        end
    end

    // R5: a data write lands in the latch even when its bits are inputs.
    a_r5_latch_always_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFS_DATA)
        |=> (latch_q == $past(bus_wdata[WIDTH-1:0])));

    // R8: writes to unmapped offsets leave every register unchanged.
    a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr != OFS_DATA && bus_addr != OFS_DIR
         && bus_addr != OFS_PULL)
        |=> ($stable(latch_q) && $stable(dir_q) && $stable(pull_q)));

endmodule

// File: rtl/gpio_port_rdmux.sv
// Read path of the GPIO port: picks the register, merges latch and pin bits
// for the data offset, and registers the result.
// Assumes pin_s is already synchronized; read data holds between reads.
module gpio_port_rdmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [PORT_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]   latch_q,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [WIDTH-1:0]   pull_q,
    input  logic [WIDTH-1:0]   pin_s,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam int PAD_W = DATA_W - WIDTH;

    logic [WIDTH-1:0] data_view;
    logic [WIDTH-1:0] rsel_val;

    // Per bit: an output shows its latch, an input shows its pin.
    for (genvar i = 0; i < WIDTH; i++) begin : g_view
        assign data_view[i] = dir_q[i] ? latch_q[i] : pin_s[i];
    end

    // Choose the value of the addressed register.
    always_comb begin
        case (decode(bus_addr))
            REG_DATA: rsel_val = data_view;
            REG_DIR:  rsel_val = dir_q;
            REG_PULL: rsel_val = pull_q;
            default:  rsel_val = '0;
        endcase
    end

    // Capture read data on a read strobe, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (bus_sel && !bus_we) bus_rdata <= {{PAD_W{1'b0}}, rsel_val};
    end

    // R9: read data only moves after a read strobe.
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

    // R7: bits above the port width never read as one.
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> (bus_rdata[DATA_W-1:WIDTH] == '0));

    // R8: unmapped offsets read as zero.
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr != OFS_DATA && bus_addr != OFS_DIR
         && bus_addr != OFS_PULL) |=> (bus_rdata == '0));

endmodule

// File: rtl/gpio_port.sv
// GPIO port top: registers, pad control, input synchronizer and read path.
// Assumes a one-cycle bus strobe and asynchronous pad inputs.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [PORT_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]   pad_in,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_pu
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pull_q;
    logic [WIDTH-1:0] pin_s;

    gpio_port_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pull_q    (pull_q)
    );

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .pin_s  (pin_s)
    );

    gpio_port_rdmux #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pull_q    (pull_q),
        .pin_s     (pin_s),
        .bus_rdata (bus_rdata)
    );

    // Drive the pads; the pull-up is gated off for output bits.
    always_comb begin
        pad_oe  = dir_q;
        pad_out = latch_q;
        pad_pu  = pull_q & ~dir_q;
    end

    // R2: a direction write shows on pad_oe the next cycle.
    a_r2_oe_from_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFS_DIR)
        |=> (pad_oe == $past(bus_wdata[WIDTH-1:0])));

    // R6: a pull-up write enables only the bits that are inputs.
    a_r6_pull_only_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFS_PULL)
        |=> (pad_pu == ($past(bus_wdata[WIDTH-1:0]) & ~pad_oe)));

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel;
    logic       bus_we;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] pad_in;
    logic [3:0] pad_oe;
    logic [3:0] pad_out;
    logic [3:0] pad_pu;
    logic [3:0] ext_en;
    logic [3:0] ext_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    // Pad model: output wins, then an external driver, then the pull-up; floating reads 0.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_en & ext_val)
                  | (~pad_oe & ~ext_en & pad_pu);

    gpio_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [3:0] ext_en;
        logic [3:0] ext_val;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h04, 8'h00, 4'h0, 4'h0, 8'h00, 4'd7}, // R7 direction reads 0
        '{1'b1, 8'h04, 8'h03, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b1, 8'h00, 8'h0A, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'hF, 4'h5, 8'h06, 4'd3}, // R3 latch bits 1:0, R4 pins 3:2
        '{1'b1, 8'h08, 8'h0C, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 8'h0E, 4'd6}, // R6 pulled inputs read 1
        '{1'b1, 8'h08, 8'h00, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 8'h02, 4'd6}, // R6 floating reads 0
        '{1'b1, 8'h04, 8'h00, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b1, 8'h00, 8'h05, 4'hF, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'hF, 4'h0, 8'h00, 4'd5}, // R5 input read ignores latch
        '{1'b1, 8'h04, 8'h0F, 4'hF, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'hF, 4'h0, 8'h05, 4'd5}, // R5 latch shows as output
        '{1'b0, 8'h04, 8'h00, 4'hF, 4'h0, 8'h0F, 4'd7},
        '{1'b1, 8'h08, 8'hFF, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h08, 8'h00, 4'h0, 4'h0, 8'h0F, 4'd7}, // R7 upper bits zero
        '{1'b1, 8'h0C, 8'hFF, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h0C, 8'h00, 4'h0, 4'h0, 8'h00, 4'd8}, // R8 unmapped reads 0
        '{1'b0, 8'h04, 8'h00, 4'h0, 4'h0, 8'h0F, 4'd8},
        '{1'b1, 8'h01, 8'h00, 4'h0, 4'h0, 8'h00, 4'd0},
        '{1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 8'h05, 4'd8}, // R8 write ignored
        '{1'b0, 8'h84, 8'h00, 4'h0, 4'h0, 8'h00, 4'd8}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus access from one negedge to the next; read data is sampled at the second.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] held;
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        ext_en = '0; ext_val = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {4'h0, pad_oe}, 8'h00);
        check("R1", {4'h0, pad_pu}, 8'h00);
        check("R1", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            ext_en = VEC[k].ext_en; ext_val = VEC[k].ext_val;
            repeat (4) @(negedge clk);
            if (VEC[k].we) bus_write(VEC[k].addr, VEC[k].wdata);
            else begin
                bus_read(VEC[k].addr, rd);
                check($sformatf("R%0d vec %0d", VEC[k].req, k), rd, VEC[k].exp);
            end
        end

        // R2 outputs follow direction and latch (dir F, latch 5)
        check("R2", {4'h0, pad_oe}, 8'h0F);
        check("R2", {4'h0, pad_out}, 8'h05);
        // R6 pull-up off for outputs (pull F, dir F)
        check("R6", {4'h0, pad_pu}, 8'h00);
        bus_write(8'h04, 8'h03);
        check("R2", {4'h0, pad_oe}, 8'h03);
        check("R6", {4'h0, pad_pu}, 8'h0C);

        // R9 read data holds across idle cycles and writes
        bus_read(8'h04, held);
        repeat (3) @(negedge clk);
        bus_write(8'h08, 8'h00);
        check("R9", bus_rdata, held);
        check("R9", held, 8'h03);

        // R4 latency: pin rises half a cycle before edge k
        bus_write(8'h04, 8'h00);
        ext_en = 4'hF; ext_val = 4'h0;
        repeat (4) @(negedge clk);
        ext_val = 4'hF;
        bus_read(8'h00, rd); check("R4 edge k", rd, 8'h00);
        bus_read(8'h00, rd); check("R4 edge k+1", rd, 8'h00);
        bus_read(8'h00, rd); check("R4 edge k+2", rd, 8'h0F);

        // R5 latch write to inputs does not disturb pin reads
        bus_write(8'h00, 8'h00);
        bus_read(8'h00, rd); check("R5", rd, 8'h0F);

        // R1 mid-run reset clears all registers
        bus_write(8'h04, 8'h0F);
        bus_write(8'h00, 8'h0A);
        bus_write(8'h08, 8'h0F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {4'h0, pad_oe}, 8'h00);
        check("R1", {4'h0, pad_pu}, 8'h00);
        check("R1", bus_rdata, 8'h00);
        bus_read(8'h08, rd); check("R1 pull", rd, 8'h00);
        bus_write(8'h04, 8'h0F);
        bus_read(8'h00, rd); check("R1 latch", rd, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule